// File: doc/BRIEF.md
# I/O Page Table Translation Engine

This block turns a DMA virtual address into a 36-bit physical address. It reads one 32-bit entry from a flat, one-level table in memory. A request gives a start address, a byte count and a direction. The engine walks the transfer one 4 KB page at a time. For each page it issues a single entry read on a request/response handshake, then checks the entry. It reports each translated page as a segment, with a physical address and a byte count.

If an entry is not present, or a write meets an entry without write permission, the walk stops at that page. The engine then drives a one-cycle capture strobe toward the register file. The strobe carries a status word and the aligned address of the failing page, and also raises the interrupt.

The table base and the window mask come from the register file as live inputs. The window mask has ones in the address bits that lie above the translated window. The engine does not move data, cache entries or handle invalidation.

Top module: `iopt_xlate`

## Requirements
- R1: `req_ready` is high exactly when the engine is idle, and a request is taken only then. The engine issues exactly one entry read per page. It holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is seen.
- R2: The entry read address is `(base_reg << 4) + (((addr & ~win_start) >> 10) & ~3)`, computed in 36 bits, where `addr` is the current address within the transfer.
- R3: Entries arrive big-endian. `mem_rsp_data[7:0]` is entry bits 31:24 and `mem_rsp_data[31:24]` is entry bits 7:0.
- R4: For a usable entry the segment address is `{entry[31:8], addr[11:0]}`. Entry bit 7 (cacheable), bits 6:3 and bit 0 (write-as-zero) have no effect on the result.
- R5: An entry whose bit 1 (present) is clear faults on both reads and writes.
- R6: An entry whose bit 2 (writable) is clear faults on writes only; reads through it translate normally.
- R7: On a fault `fault_status` is 0xC0820000. Bit 18 is also set (0xC0860000) when the faulting transfer is a read.
- R8: On a fault `fault_addr` is the current address with bits 11:0 cleared. `fault_we` and `done` are high together for exactly one cycle, and `seg_valid` stays low in that cycle.
- R9: A transfer is split at every 4 KB boundary. Each segment length is the smaller of the bytes remaining and the bytes left in the page. After a fault, no further entry read is issued.
- R10: `seg_valid` pulses for one cycle, in the cycle after the response is taken. `done` rises together with the last segment.
- R11: A request with length zero raises `done` in the next cycle, without an entry read and without a fault.
- R12: The engine waits any number of cycles for the response and drives no segment or completion while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New transfer request |
| req_ready | output | 1 | Engine idle, request accepted |
| req_addr | input | 32 | Start virtual address |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1 for write, 0 for read |
| base_reg | input | 32 | Table base from the register file |
| win_start | input | 32 | Window mask (ones above the window) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Entry read accepted |
| mem_req_addr | output | 36 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Entry data, big-endian byte order |
| seg_valid | output | 1 | One translated page segment |
| seg_pa | output | 36 | Segment physical address |
| seg_len | output | LEN_W | Segment byte count |
| done | output | 1 | Transfer finished (with or without fault) |
| fault_we | output | 1 | Fault capture strobe and interrupt raise |
| fault_status | output | 32 | Status word to capture |
| fault_addr | output | 32 | Page-aligned faulting address |

## Verification
The hardest case to reach is a fault part-way through a multi-page transfer. The earlier pages must translate cleanly, then one page is refused, and the engine must stop issuing reads at once. The bench builds every entry as an arithmetic function of its table address. It then picks start addresses, lengths and directions so that a present, writable page is followed by a write-protected one. It also sweeps all eight window sizes, three table bases and varying grant and response delays. Each walk crosses page edges at different offsets, and fault pages appear among the clean ones.

// File: rtl/iopt_xlate.sv
module iopt_xlate #(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  input  logic [31:0]      base_reg,
  input  logic [31:0]      win_start,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [35:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             seg_valid,
  output logic [35:0]      seg_pa,
  output logic [LEN_W-1:0] seg_len,
  output logic             done,
  output logic             fault_we,
  output logic [31:0]      fault_status,
  output logic [31:0]      fault_addr
);

  localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(4096);
  localparam logic [31:0] STAT_BASE = 32'hC082_0000;
  localparam logic [31:0] STAT_RD   = 32'h0004_0000;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT} state_t;

  state_t           state;
  logic [31:0]      cur_addr;
  logic [LEN_W-1:0] rem;
  logic             is_wr;

  logic [31:0]      entry;
  logic             pte_ok;
  logic [LEN_W-1:0] to_edge;
  logic [LEN_W-1:0] chunk;
  logic             unused_bits;

  assign entry       = {mem_rsp_data[7:0], mem_rsp_data[15:8],
                        mem_rsp_data[23:16], mem_rsp_data[31:24]};
  assign pte_ok      = entry[1] && (!is_wr || entry[2]);
  assign unused_bits = ^{entry[7:3], entry[0]};

  assign to_edge = PAGE_BYTES - LEN_W'(cur_addr[11:0]);
  assign chunk   = (rem < to_edge) ? rem : to_edge;

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_FETCH);
  assign mem_req_addr  = ({4'h0, base_reg} << 4)
                       + {4'h0, ((cur_addr & ~win_start) >> 10) & 32'hFFFF_FFFC};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cur_addr     <= '0;
      rem          <= '0;
      is_wr        <= 1'b0;
      seg_valid    <= 1'b0;
      seg_pa       <= '0;
      seg_len      <= '0;
      done         <= 1'b0;
      fault_we     <= 1'b0;
      fault_status <= '0;
      fault_addr   <= '0;
    end else begin
      seg_valid <= 1'b0;
      done      <= 1'b0;
      fault_we  <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          rem      <= req_len;
          is_wr    <= req_write;
          if (req_len == '0) done <= 1'b1;
          else state <= S_FETCH;
        end
        S_FETCH: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!pte_ok) begin
            fault_we     <= 1'b1;
            done         <= 1'b1;
            fault_status <= STAT_BASE | (is_wr ? 32'h0 : STAT_RD);
            fault_addr   <= {cur_addr[31:12], 12'h000};
            state        <= S_IDLE;
          end else begin
            seg_valid <= 1'b1;
            seg_pa    <= {entry[31:8], cur_addr[11:0]};
            seg_len   <= chunk;
            cur_addr  <= cur_addr + 32'(chunk);
            rem       <= rem - chunk;
            if (rem == chunk) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_FETCH;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/iopt_xlate_chk.sv
module iopt_xlate_chk #(
  parameter int LEN_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [35:0]      mem_req_addr,
  input logic             seg_valid,
  input logic [35:0]      seg_pa,
  input logic [LEN_W-1:0] seg_len,
  input logic             done,
  input logic             fault_we,
  input logic [31:0]      fault_status,
  input logic [31:0]      fault_addr
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R1

  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_we |-> done && !seg_valid); // R8

  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_we |=> !fault_we); // R8

  AST_FAULT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_we |-> (fault_status & 32'hFFFB_FFFF) == 32'hC082_0000); // R7

  AST_FAULT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fault_we |-> fault_addr[11:0] == 12'h000); // R8

  AST_SEG_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> seg_len != '0 && (int'(seg_len) + int'(seg_pa[11:0])) <= 4096); // R9

  AST_SEG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |=> !seg_valid); // R10

endmodule

bind iopt_xlate iopt_xlate_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .seg_valid(seg_valid), .seg_pa(seg_pa),
  .seg_len(seg_len), .done(done), .fault_we(fault_we),
  .fault_status(fault_status), .fault_addr(fault_addr)
);

// File: tb/test_iopt_xlate.sv
`timescale 1ns/1ps
module test_iopt_xlate;
  localparam int LEN_W = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [31:0] base_reg = '0, win_start = '0;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [35:0] mem_req_addr;
  logic [31:0] mem_rsp_data = '0;
  logic seg_valid, done, fault_we;
  logic [35:0] seg_pa;
  logic [LEN_W-1:0] seg_len;
  logic [31:0] fault_status, fault_addr;

  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  iopt_xlate #(.LEN_W(LEN_W)) i_iopt_xlate (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_of(logic [35:0] ea);
    logic [31:0] idx, h;
    idx = ea[33:2];
    h = idx * 32'h0019_660D + 32'h3C6E_F35F;
    return {h[31:8], idx[0], h[6:3], (idx % 5) != 2, (idx % 7) != 3, idx[1]};
  endfunction

  function automatic logic [35:0] ea_of(logic [31:0] a, logic [31:0] b, logic [31:0] w);
    return ({4'h0, b} << 4) + ((({4'h0, a & ~w}) >> 10) & ~36'h3);
  endfunction

  task automatic run(logic [31:0] addr, logic [LEN_W-1:0] len, logic wr,
                     logic [31:0] b, logic [31:0] w, int stall, int wt);
    logic [31:0] a, pte;
    logic [LEN_W-1:0] rem, chunk, edge_b;
    logic [35:0] ea;
    base_reg = b; win_start = w;
    chk("R1 ready when idle", 64'(req_ready), 64'd1);
    req_addr = addr; req_len = len; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk("R11 done", 64'(done), 64'd1);
      chk("R11 no fault", 64'(fault_we), 64'd0);
      chk("R11 no read", 64'(mem_req_valid), 64'd0);
      return;
    end
    a = addr; rem = len;
    forever begin
      ea = ea_of(a, b, w);
      chk("R1 read issued", 64'(mem_req_valid), 64'd1);
      chk("R1 busy", 64'(req_ready), 64'd0);
      chk("R2 entry address", 64'(mem_req_addr), 64'(ea));
      for (int i = 0; i < stall; i++) begin
        @(negedge clk);
        chk("R1 read held", 64'({mem_req_valid, mem_req_addr}), 64'({1'b1, ea}));
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk("R1 one read", 64'(mem_req_valid), 64'd0);
      for (int i = 0; i < wt; i++) begin
        @(negedge clk);
        chk("R12 quiet while waiting", 64'({seg_valid, done, fault_we}), 64'd0);
      end
      pte = pte_of(ea);
      mem_rsp_data = {pte[7:0], pte[15:8], pte[23:16], pte[31:24]};
      mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      edge_b = LEN_W'(4096) - LEN_W'(a[11:0]);
      chunk = (rem < edge_b) ? rem : edge_b;
      if (!pte[1] || (wr && !pte[2])) begin
        if (!pte[1]) chk("R5 not present faults", 64'({fault_we, done, seg_valid}), 64'b110);
        else         chk("R6 write protect faults", 64'({fault_we, done, seg_valid}), 64'b110);
        chk("R7 status", 64'(fault_status), 64'(wr ? 32'hC082_0000 : 32'hC086_0000));
        chk("R8 fault address", 64'(fault_addr), 64'({a[31:12], 12'h000}));
        @(negedge clk);
        chk("R8 one cycle", 64'({fault_we, done}), 64'd0);
        chk("R9 stop after fault", 64'(mem_req_valid), 64'd0);
        return;
      end
      chk("R3/R4 physical address", 64'(seg_pa), 64'({pte[31:8], a[11:0]}));
      chk("R9 segment length", 64'(seg_len), 64'(chunk));
      chk("R10 segment pulse", 64'({seg_valid, fault_we}), 64'b10);
      rem = rem - chunk;
      a = a + 32'(chunk);
      if (rem == 0) begin
        chk("R10 done with last", 64'(done), 64'd1);
        return;
      end
      chk("R9 not done yet", 64'(done), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset idle", 64'({req_ready, mem_req_valid, seg_valid, done, fault_we}), 64'b10000);

    run(32'hFF00_3010, 13'd16, 1'b0, 32'h0, 32'hFF00_0000, 0, 0);
    run(32'hFF00_3010, 13'd16, 1'b1, 32'h0, 32'hFF00_0000, 1, 2);
    run(32'hFF00_2000, 13'd64, 1'b1, 32'h0, 32'hFF00_0000, 0, 1);
    run(32'hFF00_2000, 13'd64, 1'b0, 32'h0, 32'hFF00_0000, 2, 0);
    run(32'hFF00_1800, 13'd8000, 1'b1, 32'h0, 32'hFF00_0000, 1, 1);
    run(32'hFF00_0FFF, 13'd2, 1'b0, 32'h0, 32'hFF00_0000, 0, 3);
    run(32'hFF00_0000, 13'd0, 1'b1, 32'h0, 32'hFF00_0000, 0, 0);

    for (int r = 0; r < 8; r++) begin
      for (int bi = 0; bi < 3; bi++) begin
        for (int k = 0; k < 6; k++) begin
          for (int wr = 0; wr < 2; wr++) begin
            logic [31:0] w, b, ad;
            logic [LEN_W-1:0] ln;
            w = ~((32'h1 << (24 + r)) - 32'h1);
            b = (bi == 0) ? 32'h0 : (bi == 1) ? 32'h0012_3400 : 32'h07FF_FC00;
            ad = w | ((32'(k) * 32'h0009_E3B7 + 32'(r) * 32'h0001_1001) & ~w);
            case (k)
              0: ln = 13'd0;
              1: ln = 13'd1;
              2: ln = 13'd37;
              3: ln = 13'd4096;
              4: ln = 13'd5000;
              default: ln = 13'd8191;
            endcase
            run(ad, ln, wr[0], b, w, k % 3, (k * 2 + wr) % 4);
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule